// File: doc/BRIEF.md
# Serial Port Interrupt Status Logic

This block builds the interrupt conditions for a synchronous serial port that has one transmit queue and one receive queue. It watches the occupancy counts of both queues, a strobe that marks the last transmitted bit leaving the shifter, a receive timeout strobe and a receive overrun strobe. From these it keeps a four-bit raw condition word. Some bits follow the queue levels. Others are sticky and are cleared by software.

A four-bit enable mask gates the raw word into a masked word. A single active-high interrupt line is the OR of the masked bits. Software reaches the block through a plain word-addressed register port with single-cycle writes and reads. A read returns its data one cycle after the request, together with a one-cycle valid pulse. The port has no back-pressure: every request is accepted in the cycle it is presented, and the block has no streaming interface.

Top module: `spi_irq_status`

## Requirements
- R1: After reset the mask, all raw condition bits, the masked word and `irq` are zero.
- R2: In the raw and masked words, overrun is bit 0, receive timeout bit 1, receive level bit 2 and transmit bit 3. Bits 31 to 4 always read as zero.
- R3: Each masked bit is 1 exactly when its raw bit and its mask bit are both 1. `irq` is the OR of the four masked bits and follows a mask write in the next cycle.
- R4: With `eot_mode` low, raw transmit bit 3 is 1 in the cycle after `tx_level` is 4 or less. It is 0 in the cycle after `tx_level` is 5 or more (queue depth 8).
- R5: With `eot_mode` high, raw bit 3 sets the cycle after a `tx_last_bit` pulse. It clears the cycle after any cycle where `tx_level` is non-zero and no pulse is present. A low queue level alone does not set it.
- R6: Raw receive bit 2 is 1 in the cycle after `rx_level` is 4 or more, and 0 in the cycle after it is 3 or less.
- R7: A `rx_timeout` pulse sets raw bit 1. The bit holds until a write of 1 to bit 1 of the clear register.
- R8: A `rx_overrun` pulse sets raw bit 0. The bit holds until a write of 1 to bit 0 of the clear register.
- R9: Writing 0 to a clear-register bit leaves the matching sticky bit unchanged.
- R10: When a set pulse and a clearing write reach the same sticky bit in one cycle, the bit ends up set.
- R11: Writes to the raw word (address 1) and the masked word (address 2) change neither those words nor the mask.
- R12: The mask register sits at address 0. It keeps `reg_wdata[3:0]` on a write and reads back with bits 31 to 4 as zero. The clear register sits at address 3.
- R13: A read presented with `reg_rd` returns `reg_rdata` with `reg_rvalid` high on the next cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_level | input | 4 | Transmit queue occupancy, 0 to 8 |
| rx_level | input | 4 | Receive queue occupancy, 0 to 8 |
| eot_mode | input | 1 | Selects last-bit source for transmit condition |
| tx_last_bit | input | 1 | One-cycle pulse when the final data bit has left |
| rx_timeout | input | 1 | One-cycle receive timeout pulse |
| rx_overrun | input | 1 | One-cycle receive overrun pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | One-cycle read data valid |
| irq | output | 1 | Combined interrupt, active high |

## Verification
A sticky bit stuck in the wrong state shows up on the very next raw-word read and on `irq` when the bit is enabled. A bit that is lost through a clear race or a wrong clear bit shows up one cycle after the offending write. A wrong level threshold or a swapped transmit source changes bit 3 or bit 2 one cycle after the occupancy crosses 4. Because of this, the bench reads the raw word right after each boundary value and after each same-cycle set/clear collision.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NUM_SRC = 4;

  // Bit positions inside the raw and masked words
  typedef enum logic [1:0] {
    SRC_OVR = 2'd0,
    SRC_RTO = 2'd1,
    SRC_RXL = 2'd2,
    SRC_TXL = 2'd3
  } src_e;

  // Word addresses of the register port
  typedef enum logic [1:0] {
    ADR_MASK  = 2'd0,
    ADR_RAW   = 2'd1,
    ADR_MSTAT = 2'd2,
    ADR_CLR   = 2'd3
  } adr_e;
endpackage

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;   // set has priority
    else if (clr_i) q_o <= 1'b0;
  end

  // R10: a set pulse always lands, even against a clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  // R7 / R8: a set bit holds without a clear request
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
  // R8 / R7: a lone clear request drops the bit
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/spi_irq_level.sv
module spi_irq_level #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tx_level,
  input  logic [CW-1:0] rx_level,
  input  logic          eot_mode,
  input  logic          last_bit_i,
  output logic          tx_raw_o,
  output logic          rx_raw_o
);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  logic eot_flag_q;
  logic eot_flag_d;
  logic tx_fifo_hit;
  logic rx_fifo_hit;

  assign tx_fifo_hit = (tx_level <= HALF);
  assign rx_fifo_hit = (rx_level >= HALF);

  always_comb begin
    eot_flag_d = eot_flag_q;
    if (last_bit_i)             eot_flag_d = 1'b1;
    else if (tx_level != '0)    eot_flag_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eot_flag_q <= 1'b0;
      tx_raw_o   <= 1'b0;
      rx_raw_o   <= 1'b0;
    end else begin
      eot_flag_q <= eot_flag_d;
      tx_raw_o   <= eot_mode ? eot_flag_d : tx_fifo_hit;
      rx_raw_o   <= rx_fifo_hit;
    end
  end

  a_r4_tx_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!eot_mode && tx_level <= HALF) |=> tx_raw_o);
  a_r4_tx_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!eot_mode && tx_level > HALF) |=> !tx_raw_o);
  a_r5_eot_set: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_mode && last_bit_i) |=> tx_raw_o);
  a_r5_eot_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_mode && !last_bit_i && tx_level != '0) |=> !tx_raw_o);
  a_r6_rx_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level >= HALF) |=> rx_raw_o);
  a_r6_rx_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level < HALF) |=> !rx_raw_o);
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int AW  = 4,
  parameter int DW  = 32,
  parameter int NS  = NUM_SRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  input  logic [NS-1:0] raw_i,
  output logic [NS-1:0] clr_o,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          irq_o
);
  localparam logic [AW-1:0] A_MASK  = AW'(ADR_MASK);
  localparam logic [AW-1:0] A_RAW   = AW'(ADR_RAW);
  localparam logic [AW-1:0] A_MSTAT = AW'(ADR_MSTAT);
  localparam logic [AW-1:0] A_CLR   = AW'(ADR_CLR);

  logic [NS-1:0] mask_q;
  logic [NS-1:0] masked;
  logic [DW-1:0] rd_mux;

  assign masked = raw_i & mask_q;
  assign irq_o  = |masked;
  assign clr_o  = (wr_en && addr == A_CLR) ? wr_data[NS-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_MASK:  rd_mux[NS-1:0] = mask_q;
      A_RAW:   rd_mux[NS-1:0] = raw_i;
      A_MSTAT: rd_mux[NS-1:0] = masked;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en && addr == A_MASK) mask_q <= wr_data[NS-1:0];
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  a_r11_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != A_MASK) |=> $stable(mask_q));
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[DW-1:NS] == '0));
  a_r13_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tx_level,
  input  logic [CW-1:0] rx_level,
  input  logic          eot_mode,
  input  logic          tx_last_bit,
  input  logic          rx_timeout,
  input  logic          rx_overrun,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_rvalid,
  output logic          irq
);
  localparam int NSTK = 2;

  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] clr_req;
  logic [NSTK-1:0]    stk_set;
  logic [NSTK-1:0]    stk_clr;
  logic [NSTK-1:0]    stk_q;

  assign stk_set[0] = rx_overrun;
  assign stk_set[1] = rx_timeout;
  assign stk_clr[0] = clr_req[SRC_OVR];
  assign stk_clr[1] = clr_req[SRC_RTO];

  for (genvar g = 0; g < NSTK; g++) begin : g_sticky
    spi_irq_sticky u_stk (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (stk_set[g]),
      .clr_i (stk_clr[g]),
      .q_o   (stk_q[g])
    );
  end

  logic tx_raw;
  logic rx_raw;

  spi_irq_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .eot_mode   (eot_mode),
    .last_bit_i (tx_last_bit),
    .tx_raw_o   (tx_raw),
    .rx_raw_o   (rx_raw)
  );

  assign raw[SRC_OVR] = stk_q[0];
  assign raw[SRC_RTO] = stk_q[1];
  assign raw[SRC_RXL] = rx_raw;
  assign raw[SRC_TXL] = tx_raw;

  spi_irq_regs #(.AW(AW), .DW(DW), .NS(NUM_SRC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .rd_en    (reg_rd),
    .addr     (reg_addr),
    .wr_data  (reg_wdata),
    .raw_i    (raw),
    .clr_o    (clr_req),
    .rd_data  (reg_rdata),
    .rd_valid (reg_rvalid),
    .irq_o    (irq)
  );

  // R1: nothing is signalled in the first cycle after reset
  a_r1_quiet: assert property (@(posedge clk)
    !rst_n |=> (!irq && raw[SRC_OVR] == 1'b0 && raw[SRC_RTO] == 1'b0));
endmodule

// File: tb/spi_irq_status_bench.sv
module spi_irq_status_bench;
  localparam logic [3:0] A_MASK = 4'd0, A_RAW = 4'd1, A_MSTAT = 4'd2, A_CLR = 4'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tx_level = 4'd8;
  logic [3:0]  rx_level = 4'd0;
  logic        eot_mode = 1'b0;
  logic        tx_last_bit = 1'b0;
  logic        rx_timeout = 1'b0;
  logic        rx_overrun = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;   // 50 MHz

  spi_irq_status u_spi_irq_status (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .eot_mode(eot_mode), .tx_last_bit(tx_last_bit), .rx_timeout(rx_timeout),
    .rx_overrun(rx_overrun), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .irq(irq)
  );

  // Monitor: pops one expected word per returned read
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R13 unexpected read data: actual %h expected none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          errors++;
          $display("FAIL %s read data: actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic chk_bit(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", t, act, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk_bit(irq, 1'b0, "R1 irq");
    rd(A_MASK, 32'h0, "R1");
    rd(A_RAW, 32'h0, "R1");
    rd(A_MSTAT, 32'h0, "R1");
    // R12 mask width
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, 32'hF, "R12");
    chk_bit(irq, 1'b0, "R3 irq no raw");
    // R4 transmit level threshold
    tx_level = 4'd4; step();
    rd(A_RAW, 32'h8, "R4");
    rd(A_MSTAT, 32'h8, "R3");
    chk_bit(irq, 1'b1, "R3 irq tx");
    tx_level = 4'd5; step();
    rd(A_RAW, 32'h0, "R4");
    chk_bit(irq, 1'b0, "R4 irq");
    // R6 receive level threshold
    rx_level = 4'd3; step();
    rd(A_RAW, 32'h0, "R6");
    rx_level = 4'd4; step();
    rd(A_RAW, 32'h4, "R6");
    rx_level = 4'd8; tx_level = 4'd0; step();
    rd(A_RAW, 32'hC, "R6");
    // R3 masking
    wr(A_MASK, 32'h4);
    rd(A_MSTAT, 32'h4, "R3");
    rd(A_MASK, 32'h4, "R12");
    wr(A_MASK, 32'h0);
    chk_bit(irq, 1'b0, "R3 irq masked");
    rd(A_MSTAT, 32'h0, "R3");
    // R7 / R9 timeout sticky
    tx_level = 4'd8; rx_level = 4'd0; step();
    rx_timeout = 1'b1; step(); rx_timeout = 1'b0;
    rd(A_RAW, 32'h2, "R7");
    repeat (3) step();
    rd(A_RAW, 32'h2, "R7");
    wr(A_CLR, 32'h0);
    rd(A_RAW, 32'h2, "R9");
    wr(A_CLR, 32'h1);
    rd(A_RAW, 32'h2, "R9");
    wr(A_MASK, 32'h2);
    chk_bit(irq, 1'b1, "R7 irq");
    wr(A_CLR, 32'h2);
    rd(A_RAW, 32'h0, "R7");
    chk_bit(irq, 1'b0, "R7 irq cleared");
    // R8 overrun sticky
    rx_overrun = 1'b1; step(); rx_overrun = 1'b0;
    rd(A_RAW, 32'h1, "R8");
    rd(A_MSTAT, 32'h0, "R3");
    wr(A_CLR, 32'h1);
    rd(A_RAW, 32'h0, "R8");
    // R10 set beats clear in the same cycle
    rx_overrun = 1'b1; wr(A_CLR, 32'h1); rx_overrun = 1'b0;
    rd(A_RAW, 32'h1, "R10");
    rx_timeout = 1'b1; wr(A_CLR, 32'h2); rx_timeout = 1'b0;
    rd(A_RAW, 32'h3, "R10");
    // R11 read-only words
    wr(A_MSTAT, 32'hF);
    wr(A_RAW, 32'hF);
    rd(A_MASK, 32'h2, "R11");
    rd(A_RAW, 32'h3, "R11");
    rd(A_MSTAT, 32'h2, "R2");
    wr(A_CLR, 32'h3);
    rd(A_RAW, 32'h0, "R8");
    // R5 end-of-transmission source
    eot_mode = 1'b1; tx_level = 4'd2; step();
    rd(A_RAW, 32'h0, "R5");
    tx_level = 4'd0; step();
    rd(A_RAW, 32'h0, "R5");
    tx_last_bit = 1'b1; step(); tx_last_bit = 1'b0;
    rd(A_RAW, 32'h8, "R5");
    repeat (2) step();
    rd(A_RAW, 32'h8, "R5");
    tx_level = 4'd1; step();
    rd(A_RAW, 32'h0, "R5");
    eot_mode = 1'b0; step();
    rd(A_RAW, 32'h8, "R4");
    // R13 valid lasts one cycle
    step();
    chk_bit(reg_rvalid, 1'b0, "R13 valid drop");
    step();
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R13 missing reads: actual %0d pending expected 0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule